// File: doc/BRIEF.md
# Unsigned Integer to Single-Precision Converter with Lane Merge

This block turns an unsigned integer operand into an IEEE-754 single-precision value and places it in the lowest 32-bit lane of a wide vector result. The operand is either 64 bits or 32 bits wide. A 64-bit request takes effect only while the wide-address mode input is high. Otherwise the upper half of the integer input is disregarded. The value is rounded in one of four directed or nearest modes. The mode comes either from a per-operation override field or from a global control field.

The result lane is merged with bits 127:32 of a companion vector operand, and every bit above 127 up to the configured vector length is cleared. An inexact flag goes with the result. It is set whenever rounding dropped nonzero bits. The block has a single output register, so a result appears one clock after its operands are presented. A new conversion may start on every cycle.

Top module: `uint_to_fp32_merge`

## Requirements
- R1: When `wide_op` is low, only `src_int[31:0]` is converted and `src_int[63:32]` has no effect on any output.
- R2: When `wide_op` and `long_mode` are both high, all 64 bits of `src_int` are converted. When `long_mode` is low, `wide_op` is ignored and the conversion uses `src_int[31:0]` only.
- R3: The rounding mode is `rc_embedded` when `src_is_reg` and `rc_override` are both high. Otherwise it is `rc_global`.
- R4: Rounding-mode encoding is 2'b00 nearest-even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, and 2'b11 toward zero. `dst_vec[31:0]` is the correctly rounded single-precision value of the operand under the selected mode.
- R5: `inexact` is high exactly when the rounded result differs from the operand value. Any operand below 2^24 gives `inexact` low.
- R6: An operand of zero gives `dst_vec[31:0]` = 32'h0000_0000 with `inexact` low. Bit 31 of the result (the sign) is always 0.
- R7: When rounding up carries out of the 23-bit fraction, the exponent field rises by one and the fraction field becomes zero. For example, 2^25-1 under nearest-even gives 32'h4C00_0000.
- R8: `dst_vec[127:32]` equals `src_vec[127:32]` of the same operation.
- R9: `dst_vec` bits from 128 up to VLEN-1 are always zero.
- R10: Outputs are registered. A result appears on the first rising clock edge after its operands are applied. While `rst_n` is low, `dst_vec` and `inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| src_int | input | 64 | Unsigned integer operand |
| wide_op | input | 1 | Requests a 64-bit operand |
| long_mode | input | 1 | Wide-address mode; without it, `wide_op` is ignored |
| src_is_reg | input | 1 | Operand comes from a register (enables the override) |
| rc_override | input | 1 | Per-operation rounding override enable |
| rc_embedded | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| src_vec | input | 128 | Vector supplying result bits 127:32 |
| dst_vec | output | VLEN | Merged vector result (VLEN defaults to 512) |
| inexact | output | 1 | Rounding dropped nonzero bits |

## Verification
Every result, including the merged upper lanes, the zeroed high part and the inexact flag, is due on the first rising edge after its operands are applied. The bench drives operands on a falling edge and samples the outputs on the next falling edge, half a period after the capturing edge. Each check compares the full vector and the flag against a reference that rounds by comparing the remainder with half a unit in the last place. The reset state is sampled while reset is still held.

// File: rtl/fp_cvt_pkg.sv
package fp_cvt_pkg;

  localparam int FRAC_W   = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;
  localparam int FP_W     = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // Increment decision for a positive magnitude.
  function automatic logic rnd_increment(input rmode_e rm, input logic lsb,
                                         input logic g, input logic s);
    logic inc;
    case (rm)
      RM_NEAR: inc = g & (s | lsb);
      RM_UP:   inc = g | s;
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction

  // Pack sign (always 0), exponent and fraction.
  function automatic logic [FP_W-1:0] pack_pos(input logic [EXP_W-1:0] e,
                                               input logic [FRAC_W-1:0] f);
    return {1'b0, e, f};
  endfunction

endpackage

// File: rtl/cvt_rm_select.sv
module cvt_rm_select
  import fp_cvt_pkg::*;
(
  input  logic       src_is_reg,
  input  logic       rc_override,
  input  logic [1:0] rc_embedded,
  input  logic [1:0] rc_global,
  output rmode_e     rm
);
  logic use_embedded;

  always_comb begin
    use_embedded = src_is_reg & rc_override;
    rm = use_embedded ? rmode_e'(rc_embedded) : rmode_e'(rc_global);
  end
endmodule

// File: rtl/cvt_normalize.sv
module cvt_normalize
  import fp_cvt_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic [IN_W-1:0]         x,
  output logic                    is_zero,
  output logic [$clog2(IN_W)-1:0] lead_pos,
  output logic [FRAC_W-1:0]       frac,
  output logic                    guard,
  output logic                    sticky
);
  localparam int POS_W  = $clog2(IN_W);
  localparam int G_IDX  = IN_W - 2 - FRAC_W;

  logic [POS_W-1:0] shamt;
  logic [IN_W-1:0]  norm;

  // Leading-one detector: highest set bit wins.
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (x[i]) lead_pos = POS_W'(i);
    end
  end

  always_comb begin
    is_zero = (x == '0);
    shamt   = POS_W'(IN_W - 1) - lead_pos;
    norm    = x << shamt;
    frac    = norm[IN_W-2 -: FRAC_W];
    guard   = norm[G_IDX];
    sticky  = |norm[G_IDX-1:0];
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import fp_cvt_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic              is_zero,
  input  logic [POS_W-1:0]  lead_pos,
  input  logic [FRAC_W-1:0] frac,
  input  logic              guard,
  input  logic              sticky,
  input  rmode_e            rm,
  output logic [FP_W-1:0]   fp,
  output logic              inexact,
  output logic              carry
);
  logic              inc;
  logic [FRAC_W:0]   sum;
  logic [EXP_W-1:0]  expo;

  always_comb begin
    inc     = rnd_increment(rm, frac[0], guard, sticky);
    sum     = {1'b0, frac} + (FRAC_W+1)'(inc);
    carry   = sum[FRAC_W] & ~is_zero;
    expo    = EXP_W'(EXP_BIAS) + EXP_W'(lead_pos) + EXP_W'(carry);
    inexact = (guard | sticky) & ~is_zero;
    if (is_zero) fp = '0;
    else         fp = pack_pos(expo, sum[FRAC_W-1:0]);
  end
endmodule

// File: rtl/cvt_lane_merge.sv
module cvt_lane_merge
  import fp_cvt_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic [FP_W-1:0]  fp,
  input  logic [127:0]     src_vec,
  output logic [VLEN-1:0]  dst
);
  assign dst[FP_W-1:0]  = fp;
  assign dst[127:FP_W]  = src_vec[127:FP_W];

  generate
    if (VLEN > 128) begin : g_upper
      assign dst[VLEN-1:128] = '0;
    end
  endgenerate
endmodule

// File: rtl/uint_to_fp32_merge.sv
module uint_to_fp32_merge
  import fp_cvt_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int IN_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [63:0]     src_int,
  input  logic            wide_op,
  input  logic            long_mode,
  input  logic            src_is_reg,
  input  logic            rc_override,
  input  logic [1:0]      rc_embedded,
  input  logic [1:0]      rc_global,
  input  logic [127:0]    src_vec,
  output logic [VLEN-1:0] dst_vec,
  output logic            inexact
);
  localparam int POS_W = $clog2(IN_W);

  // Named internal events, visible to the bound checker.
  logic              eff_wide;
  logic [IN_W-1:0]   operand;
  rmode_e            sel_rm;
  logic              norm_zero;
  logic [POS_W-1:0]  lead_pos;
  logic [FRAC_W-1:0] norm_frac;
  logic              guard_bit;
  logic              sticky_bit;
  logic [FP_W-1:0]   conv_fp;
  logic              conv_inexact;
  logic              rnd_carry;
  logic [VLEN-1:0]   merged;

  always_comb begin
    eff_wide = wide_op & long_mode;
    operand  = eff_wide ? IN_W'(src_int) : IN_W'(src_int[31:0]);
  end

  cvt_rm_select u_rm (
    .src_is_reg  (src_is_reg),
    .rc_override (rc_override),
    .rc_embedded (rc_embedded),
    .rc_global   (rc_global),
    .rm          (sel_rm)
  );

  cvt_normalize #(.IN_W(IN_W)) u_norm (
    .x        (operand),
    .is_zero  (norm_zero),
    .lead_pos (lead_pos),
    .frac     (norm_frac),
    .guard    (guard_bit),
    .sticky   (sticky_bit)
  );

  cvt_round #(.POS_W(POS_W)) u_rnd (
    .is_zero  (norm_zero),
    .lead_pos (lead_pos),
    .frac     (norm_frac),
    .guard    (guard_bit),
    .sticky   (sticky_bit),
    .rm       (sel_rm),
    .fp       (conv_fp),
    .inexact  (conv_inexact),
    .carry    (rnd_carry)
  );

  cvt_lane_merge #(.VLEN(VLEN)) u_merge (
    .fp      (conv_fp),
    .src_vec (src_vec),
    .dst     (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_vec <= '0;
      inexact <= 1'b0;
    end else begin
      dst_vec <= merged;
      inexact <= conv_inexact;
    end
  end
endmodule

// File: rtl/uint_to_fp32_merge_chk.sv
module uint_to_fp32_merge_chk #(
  parameter int VLEN = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic [63:0]     src_int,
  input logic            wide_op,
  input logic            long_mode,
  input logic            src_is_reg,
  input logic            rc_override,
  input logic [1:0]      rc_global,
  input logic [1:0]      sel_rm,
  input logic [127:0]    src_vec,
  input logic [VLEN-1:0] dst_vec,
  input logic            inexact,
  input logic            rnd_carry,
  input logic [31:0]     conv_fp
);
  logic seen;
  logic upper_quiet;
  logic op_zero;
  logic op_small;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    upper_quiet = !(wide_op && long_mode) || (src_int[63:32] == 32'd0);
    op_zero     = (src_int[31:0] == 32'd0) && upper_quiet;
    op_small    = (src_int[31:24] == 8'd0) && upper_quiet;
  end

  assert_rm_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_is_reg || !rc_override) |-> (sel_rm == rc_global));

  assert_wide_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!long_mode) && $past(src_int[31:0] == 32'd0)) |-> (dst_vec[31:0] == 32'd0));

  assert_small_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_small)) |-> !inexact);

  assert_zero_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_zero)) |-> (dst_vec[31:0] == 32'd0 && !inexact));

  assert_sign_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_vec[31]);

  assert_carry_frac_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_carry |-> (conv_fp[22:0] == 23'd0));

  assert_upper_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dst_vec[127:32] == $past(src_vec[127:32])));

  assert_high_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vec[VLEN-1:128] == '0);
endmodule

bind uint_to_fp32_merge uint_to_fp32_merge_chk #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_int     (src_int),
  .wide_op     (wide_op),
  .long_mode   (long_mode),
  .src_is_reg  (src_is_reg),
  .rc_override (rc_override),
  .rc_global   (rc_global),
  .sel_rm      (sel_rm),
  .src_vec     (src_vec),
  .dst_vec     (dst_vec),
  .inexact     (inexact),
  .rnd_carry   (rnd_carry),
  .conv_fp     (conv_fp)
);

// File: tb/sim_uint_to_fp32_merge.sv
module sim_uint_to_fp32_merge;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 512;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [63:0]     src_int = '0;
  logic            wide_op = 1'b0;
  logic            long_mode = 1'b0;
  logic            src_is_reg = 1'b0;
  logic            rc_override = 1'b0;
  logic [1:0]      rc_embedded = '0;
  logic [1:0]      rc_global = '0;
  logic [127:0]    src_vec = '0;
  logic [VLEN-1:0] dst_vec;
  logic            inexact;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uint_to_fp32_merge #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .src_int(src_int), .wide_op(wide_op),
    .long_mode(long_mode), .src_is_reg(src_is_reg), .rc_override(rc_override),
    .rc_embedded(rc_embedded), .rc_global(rc_global), .src_vec(src_vec),
    .dst_vec(dst_vec), .inexact(inexact)
  );

  // Reference: rounds by comparing the discarded remainder with one half ulp.
  function automatic void ref_conv(input logic [63:0] x, input logic [1:0] rm,
                                   output logic [31:0] f, output logic ix);
    int p;
    int sh;
    logic [63:0] q, rem, half;
    logic up;
    f = 32'd0; ix = 1'b0;
    if (x == 64'd0) return;
    p = 63;
    while (!x[p]) p--;
    if (p <= 23) begin
      q = x << (23 - p);
    end else begin
      sh   = p - 23;
      q    = x >> sh;
      rem  = x & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      ix   = (rem != 64'd0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b10:   up = ix;
        default: up = 1'b0;
      endcase
      q = q + 64'(up);
      if (q[24]) begin
        q = q >> 1;
        p = p + 1;
      end
    end
    f = {1'b0, 8'(p + 127), q[22:0]};
  endfunction

  task automatic run_case(input string tag, input logic [63:0] x,
                          input logic w, input logic lm, input logic reg_src,
                          input logic ovr, input logic [1:0] emb,
                          input logic [1:0] glob, input logic [127:0] v);
    logic [63:0]     opnd;
    logic [1:0]      rm;
    logic [31:0]     f;
    logic            ix;
    logic [VLEN-1:0] exp_dst;
    src_int = x; wide_op = w; long_mode = lm; src_is_reg = reg_src;
    rc_override = ovr; rc_embedded = emb; rc_global = glob; src_vec = v;
    @(negedge clk);
    opnd = (w && lm) ? x : {32'd0, x[31:0]};
    rm   = (reg_src && ovr) ? emb : glob;
    ref_conv(opnd, rm, f, ix);
    exp_dst = '0;
    exp_dst[127:0] = {v[127:32], f};
    tests++;
    if (dst_vec !== exp_dst || inexact !== ix) begin
      fails++;
      $display("FAIL %s: x=%h lo=%h ix=%b hi_ok=%0d expected lo=%h ix=%b",
               tag, x, dst_vec[31:0], inexact, dst_vec[VLEN-1:32] == exp_dst[VLEN-1:32],
               f, ix);
    end
  endtask

  task automatic t_reset;
    tests++;
    if (dst_vec !== '0 || inexact !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: lo=%h ix=%b expected 0/0", dst_vec[31:0], inexact);
    end
  endtask

  task automatic t_zero;
    run_case("R6 zero 32", 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, {4{32'hA5A5_5A5A}});
    run_case("R6 zero 64", 64'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, {4{32'h1234_5678}});
  endtask

  task automatic t_exact;
    run_case("R5 one", 64'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, '1);
    run_case("R5 2^24-1", 64'hFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, '1);
    run_case("R5 2^63 exact", 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, '0);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      run_case("R4 2^24+1", 64'h100_0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m), {4{32'hCAFE_F00D}});
      run_case("R4 2^24+3", 64'h100_0003, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m), {4{32'hCAFE_F00D}});
      run_case("R4 ones32", 64'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'(m), '0);
      run_case("R2 ones64", '1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'(m), '1);
    end
  endtask

  task automatic t_carry;
    run_case("R7 2^25-1 nearest", 64'h1FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, '0);
    run_case("R7 2^25-1 up", 64'h1FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, '0);
    run_case("R7 2^25-1 zero", 64'h1FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, '0);
  endtask

  task automatic t_rm_source;
    run_case("R3 override used", 64'h100_0001, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b11, '0);
    run_case("R3 memory source", 64'h100_0001, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11, '0);
    run_case("R3 override off", 64'h100_0001, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b11, '0);
  endtask

  task automatic t_width;
    run_case("R1 upper ignored", 64'hFFFF_FFFF_0000_0007, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, '0);
    run_case("R2 wide ignored", 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, '0);
    run_case("R2 wide taken", 64'h0000_0001_0000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10, '0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x;
      x = {$urandom, $urandom} >> ($urandom % 64);
      run_case("R4 R8 R9 random", x, 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 2'($urandom), 2'($urandom),
               {$urandom, $urandom, $urandom, $urandom});
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zero();
    t_exact();
    t_modes();
    t_carry();
    t_rm_source();
    t_width();
    t_random();
    finish_run();
  end
endmodule